// File: doc/BRIEF.md
# Multi-Lane Link Self-Test Result Register

This block gathers the outcome of an at-speed interconnect self-test across six deserializer lanes. It presents the outcome as a 12-bit test data register behind a boundary-scan style capture/shift interface. After the self-test instruction is loaded, the run starts once the test controller reports Run-Test/Idle. A shared window controller then opens a guard interval. During this interval error strobes are ignored, so that the link partner, which may start up to a few thousand system clocks later, can begin sending its pattern. A measurement interval of fixed length follows. Each lane counts its own error strobes during the measurement interval. When the interval closes, every lane latches a completion flag and a pass flag. A lane passes when its error count keeps the bit-error ratio better than one in ten million.

The lane error checkers downstream of the receivers are modelled as one error strobe per lane per system clock. All logic runs on the system clock. The instruction-loaded pulse, instruction-active level, Run-Test/Idle indication and the capture/shift strobes are taken to be already synchronised to that clock. The guard length, window length and error allowance are parameters. The allowance defaults to the largest count that stays strictly under the 1e-7 ratio for ten bits per clock.

Top module: `lbist_result_reg`

## Requirements
- R1: Register layout: bit 2k+1 is the completion flag and bit 2k is the pass flag of lane k+1 (k = 0..5), so bit 11 is lane 6 completion and bit 0 is lane 1 pass.
- R2: A capture strobe loads all 12 status bits in parallel on the next clock edge and takes priority over a shift strobe.
- R3: A shift strobe moves the register one place toward `tdo`, which always shows bit 0. The `tdi` value enters at bit 11.
- R4: The instruction-loaded pulse clears every completion and pass flag and arms a new run.
- R5: An armed run starts only on a clock where the instruction is active and `tap_rti` is high. Without a new load, nothing starts.
- R6: During the first SKEW_CYCLES clocks of a run, error strobes on any lane are ignored.
- R7: The measurement interval lasts exactly WINDOW_CYCLES clocks after the guard interval. All completion flags set together on the edge that ends it.
- R8: A lane passes when the errors counted over the measurement interval, including its last clock, do not exceed ALLOWED_ERRS. Strobes after the interval are ignored.
- R9: A pass flag reads 0 whenever its lane's completion flag is 0.
- R10: Dropping the instruction-active level before the interval ends aborts the run. The completion flags stay 0 until a new load and full run.
- R11: Lanes are counted and judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_sel_i | input | 1 | Self-test instruction currently active |
| bist_load_i | input | 1 | One-clock pulse: self-test instruction just loaded |
| tap_rti_i | input | 1 | Test controller is in Run-Test/Idle |
| lane_err_i | input | NUM_CH | Per-lane error strobe from the pattern checkers |
| dr_capture_i | input | 1 | Capture-DR strobe |
| dr_shift_i | input | 1 | Shift-DR strobe |
| tdi_i | input | 1 | Serial data into the register |
| tdo_o | output | 1 | Serial data out, bit 0 of the register |

## Verification
The assertions take for granted that the load pulse lasts one clock and arrives while the instruction is active. They also assume that capture and shift strobes come only while no run is in progress, so a sample never lands mid-update. The stimulus raises the instruction level before pulsing load. It drives all inputs on the falling edge and places error strobes at clock offsets from the run start that are computed from the guard and window lengths. It reads the register only after the window has closed or the run has been aborted. Boundary strobes are placed on the last guard clock, the last measurement clock and the first clock after the window.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int BITS_PER_CLK = 10;
    localparam longint BER_DENOM = 64'd10_000_000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARMED,
        PH_GUARD,
        PH_MEASURE,
        PH_DONE
    } lbist_phase_e;

    typedef struct packed {
        logic done;
        logic pass;
    } lane_stat_t;

    // Largest error count that keeps errors / (window * bits) strictly below 1/BER_DENOM
    function automatic int err_budget(input int window);
        longint bits;
        bits = longint'(window) * BITS_PER_CLK;
        return int'((bits - 1) / BER_DENOM);
    endfunction

endpackage

// File: rtl/lbist_window_ctrl.sv
module lbist_window_ctrl
    import lbist_pkg::*;
#(
    parameter int SKEW_CYCLES   = 4096,
    parameter int WINDOW_CYCLES = 2_200_000
) (
    input  logic clk,
    input  logic rst,
    input  logic bist_sel_i,
    input  logic bist_load_i,
    input  logic tap_rti_i,
    output logic clear_o,
    output logic measure_o,
    output logic finish_o
);

    localparam int MAXC = (SKEW_CYCLES > WINDOW_CYCLES) ? SKEW_CYCLES : WINDOW_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] GUARD_LAST = CW'(SKEW_CYCLES - 1);
    localparam logic [CW-1:0] MEAS_LAST  = CW'(WINDOW_CYCLES - 1);

    lbist_phase_e ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else if (bist_load_i) begin
            ph_q  <= PH_ARMED;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_ARMED: begin
                    if (!bist_sel_i) ph_q <= PH_IDLE;
                    else if (tap_rti_i) begin
                        ph_q  <= PH_GUARD;
                        cnt_q <= '0;
                    end
                end
                PH_GUARD: begin
                    if (!bist_sel_i) ph_q <= PH_IDLE;
                    else if (cnt_q == GUARD_LAST) begin
                        ph_q  <= PH_MEASURE;
                        cnt_q <= '0;
                    end else cnt_q <= cnt_q + CW'(1);
                end
                PH_MEASURE: begin
                    if (!bist_sel_i) ph_q <= PH_IDLE;
                    else if (cnt_q == MEAS_LAST) ph_q <= PH_DONE;
                    else cnt_q <= cnt_q + CW'(1);
                end
                default: ph_q <= ph_q;
            endcase
        end
    end

    assign clear_o   = bist_load_i;
    assign measure_o = (ph_q == PH_MEASURE) && bist_sel_i && !bist_load_i;
    assign finish_o  = measure_o && (cnt_q == MEAS_LAST);

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_GUARD || ph_q == PH_MEASURE) && !bist_sel_i && !bist_load_i) |=> (ph_q == PH_IDLE));

    // R7
    window_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (measure_o && !finish_o) |=> (ph_q == PH_MEASURE || !bist_sel_i || bist_load_i || $past(bist_load_i)));

    // R5
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && !bist_load_i) |=> !measure_o);

    // R7
    finish_once_chk: assert property (@(posedge clk) disable iff (rst)
        finish_o |=> !finish_o);

endmodule

// File: rtl/lbist_lane_checker.sv
module lbist_lane_checker
    import lbist_pkg::*;
#(
    parameter int ALLOWED_ERRS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       measure_i,
    input  logic       finish_i,
    input  logic       err_i,
    output lane_stat_t stat_o
);

    localparam int EW = $clog2(ALLOWED_ERRS + 2);
    localparam logic [EW-1:0] LIMIT = EW'(ALLOWED_ERRS);
    localparam logic [EW-1:0] OVER  = EW'(ALLOWED_ERRS + 1);

    logic [EW-1:0] err_cnt_q, err_cnt_d;
    lane_stat_t    stat_q;

    // saturating count: once above the allowance the exact value no longer matters
    always_comb begin
        err_cnt_d = err_cnt_q;
        if (measure_i && err_i && err_cnt_q != OVER)
            err_cnt_d = err_cnt_q + EW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            err_cnt_q <= '0;
            stat_q    <= '0;
        end else begin
            err_cnt_q <= err_cnt_d;
            if (finish_i) begin
                stat_q.done <= 1'b1;
                stat_q.pass <= (err_cnt_d <= LIMIT);
            end
        end
    end

    assign stat_o = stat_q;

    // R9
    pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_q.done |-> !stat_q.pass);

    // R6
    ignore_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (!measure_i && !clear_i) |=> $stable(err_cnt_q));

    // R8
    budget_chk: assert property (@(posedge clk) disable iff (rst)
        (finish_i && err_cnt_q == OVER) |=> (stat_q.done && !stat_q.pass));

endmodule

// File: rtl/lbist_dr.sv
module lbist_dr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_i,
    input  logic         shift_i,
    input  logic [W-1:0] par_i,
    input  logic         tdi_i,
    output logic         tdo_o
);

    logic [W-1:0] dr_q;

    always_ff @(posedge clk) begin
        if (rst)            dr_q <= '0;
        else if (capture_i) dr_q <= par_i;
        else if (shift_i)   dr_q <= {tdi_i, dr_q[W-1:1]};
    end

    assign tdo_o = dr_q[0];

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> (dr_q == $past(par_i)));

    // R3
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !capture_i) |=> (dr_q[W-1] == $past(tdi_i)));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !capture_i) |=> (dr_q[W-2:0] == $past(dr_q[W-1:1])));

endmodule

// File: rtl/lbist_result_reg.sv
module lbist_result_reg
    import lbist_pkg::*;
#(
    parameter int NUM_CH        = 6,
    parameter int SKEW_CYCLES   = 4096,
    parameter int WINDOW_CYCLES = 2_200_000,
    parameter int ALLOWED_ERRS  = lbist_pkg::err_budget(WINDOW_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bist_sel_i,
    input  logic              bist_load_i,
    input  logic              tap_rti_i,
    input  logic [NUM_CH-1:0] lane_err_i,
    input  logic              dr_capture_i,
    input  logic              dr_shift_i,
    input  logic              tdi_i,
    output logic              tdo_o
);

    localparam int DR_W = 2 * NUM_CH;

    logic clear, measure, finish;
    lane_stat_t  stat [NUM_CH];
    logic [DR_W-1:0]   status_vec;
    logic [NUM_CH-1:0] done_bits;

    lbist_window_ctrl #(
        .SKEW_CYCLES  (SKEW_CYCLES),
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bist_sel_i (bist_sel_i),
        .bist_load_i(bist_load_i),
        .tap_rti_i  (tap_rti_i),
        .clear_o    (clear),
        .measure_o  (measure),
        .finish_o   (finish)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        lbist_lane_checker #(
            .ALLOWED_ERRS(ALLOWED_ERRS)
        ) i_lane (
            .clk      (clk),
            .rst      (rst),
            .clear_i  (clear),
            .measure_i(measure),
            .finish_i (finish),
            .err_i    (lane_err_i[g]),
            .stat_o   (stat[g])
        );
        // lane g+1: completion at 2g+1, pass at 2g
        assign status_vec[2*g +: 2] = stat[g];
        assign done_bits[g]         = stat[g].done;
    end

    lbist_dr #(.W(DR_W)) i_dr (
        .clk      (clk),
        .rst      (rst),
        .capture_i(dr_capture_i),
        .shift_i  (dr_shift_i),
        .par_i    (status_vec),
        .tdi_i    (tdi_i),
        .tdo_o    (tdo_o)
    );

    // R4
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        bist_load_i |=> (done_bits == '0));

    // R7
    done_together_chk: assert property (@(posedge clk) disable iff (rst)
        (done_bits == '0 || done_bits == '1));

endmodule

// File: tb/test_lbist_result_reg.sv
module test_lbist_result_reg;

    localparam int NCH   = 6;
    localparam int SKEW  = 8;
    localparam int WIN   = 64;
    localparam int ALLOW = 2;
    localparam int DW    = 2 * NCH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, load = 1'b0, rti = 1'b0;
    logic [NCH-1:0] err = '0;
    logic cap = 1'b0, sh = 1'b0, tdi = 1'b0;
    logic tdo;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    lbist_result_reg #(
        .NUM_CH(NCH), .SKEW_CYCLES(SKEW), .WINDOW_CYCLES(WIN), .ALLOWED_ERRS(ALLOW)
    ) i_lbist_result_reg (
        .clk(clk), .rst(rst), .bist_sel_i(sel), .bist_load_i(load), .tap_rti_i(rti),
        .lane_err_i(err), .dr_capture_i(cap), .dr_shift_i(sh), .tdi_i(tdi), .tdo_o(tdo)
    );

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] got_word;
    event          got_ev;

    // error pattern per scenario; j = clocks after the run start edge
    function automatic logic [NCH-1:0] mask_for(input int scen, input int j);
        logic [NCH-1:0] m = '0;
        case (scen)
            1: begin
                if (j == 2 || j == 4 || j == SKEW) m[0] = 1'b1;              // guard only
                if (j == 20 || j == 30) m[1] = 1'b1;                          // exactly allowance
                if (j == 20 || j == 30 || j == 40) m[2] = 1'b1;               // one over
                if (j == 10 || j > SKEW + WIN) m[3] = 1'b1;                   // after window
                if (j == 30 || j == 31 || j == SKEW + WIN) m[4] = 1'b1;       // last clock counts
                if (j <= SKEW + 1) m[5] = 1'b1;                               // guard flood + 1
            end
            2: if (j > SKEW && j <= SKEW + WIN) m = '1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // R1 R8 R11: expected word from the pattern
    function automatic logic [DW-1:0] expect_for(input int scen);
        logic [DW-1:0] w = '0;
        for (int c = 0; c < NCH; c++) begin
            int n = 0;
            for (int j = SKEW + 1; j <= SKEW + WIN; j++) n += mask_for(scen, j)[c];
            w[2*c+1] = 1'b1;
            w[2*c]   = (n <= ALLOW);
        end
        return w;
    endfunction

    task automatic push(input logic [DW-1:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    // capture (optional) then shift DW bits out, feeding pat in
    task automatic read_dr(input bit do_cap, input logic [DW-1:0] pat);
        if (do_cap) begin
            cap = 1'b1;
            @(posedge clk); @(negedge clk);
            cap = 1'b0;
        end
        for (int i = 0; i < DW; i++) begin
            got_word[i] = tdo;
            sh  = 1'b1;
            tdi = pat[i];
            @(posedge clk); @(negedge clk);
        end
        sh = 1'b0; tdi = 1'b0;
        ->got_ev;
        @(negedge clk);
    endtask

    task automatic do_load();
        sel = 1'b1; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // start edge is the first posedge after rti rises
    task automatic run(input int scen);
        rti = 1'b1;
        for (int j = 1; j <= SKEW + WIN + 4; j++) begin
            @(negedge clk);
            rti = 1'b0;
            err = mask_for(scen, j);
        end
        @(negedge clk);
        err = '0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R1: unexpected read got=%h exp=none", got_word);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int c = 0; c < NCH; c++) begin
                    total++;
                    if (got_word[2*c +: 2] !== e[2*c +: 2]) begin
                        bad++;
                        $display("FAIL %s lane%0d: got=%b exp=%b", t, c + 1,
                                 got_word[2*c +: 2], e[2*c +: 2]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        push('0, "R4 reset");
        read_dr(1'b1, '0);

        // R5: loaded but controller never in Run-Test/Idle
        do_load();
        repeat (SKEW + WIN + 10) @(negedge clk);
        push('0, "R5 no-rti");
        read_dr(1'b1, '0);

        // R7 R8: clean run, all lanes pass
        run(0);
        push(expect_for(0), "R7 clean");
        read_dr(1'b1, '0);

        // R4: new load clears finished results
        do_load();
        push('0, "R4 load-clear");
        read_dr(1'b1, '0);

        // R6 R8 R11: mixed pattern with boundary strobes
        run(1);
        push(expect_for(1), "R8 mixed");
        read_dr(1'b1, 12'hA5C);
        // R3: shifted-in pattern comes back out unchanged
        push(12'hA5C, "R3 passthrough");
        read_dr(1'b0, '0);

        // R11: every lane flooded
        do_load();
        run(2);
        push(expect_for(2), "R11 flood");
        read_dr(1'b1, '0);

        // R10: abort mid-measurement
        do_load();
        rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
        repeat (SKEW + 10) @(negedge clk);
        sel = 1'b0;
        repeat (WIN + 10) @(negedge clk);
        push('0, "R10 abort");
        read_dr(1'b1, '0);

        // R5 R10: level back and rti again without load, nothing restarts
        sel = 1'b1; rti = 1'b1;
        repeat (SKEW + WIN + 10) @(negedge clk);
        rti = 1'b0;
        push('0, "R5 no-reload");
        read_dr(1'b1, '0);

        // R2 R9: capture while shift held, pass flags with done
        do_load();
        run(0);
        sh = 1'b1; cap = 1'b1;
        @(posedge clk); @(negedge clk);
        sh = 1'b0; cap = 1'b0;
        push(expect_for(0), "R2 capture-priority");
        read_dr(1'b0, '0);

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule